// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the interrupt status flags and the per-source enable bits for a 16-bit timer/counter. The timer has one input-capture unit and three output-compare channels. The timer core sends it single-cycle strobes: overflow, counter at TOP, capture-pin event, compare match on channels A, B and C, and forced compare on channels A, B and C. From these strobes the block sets five flags. Each flag stays set until one of two things clears it. Software can write a one to the flag's bit, or the interrupt controller can acknowledge that source when it takes the vector.

The block drives one interrupt request per source. A request is high only while its flag is set, its enable bit is set and the global interrupt enable is high. A compare match does not set its flag at once. It is held for one timer clock in a small two-state machine per channel (`CD_IDLE`, `CD_ARMED`), so the flag appears one timer clock after the match. That timer clock is marked by the `tick` enable, so the delay still follows a prescaled count. A single-bit address selects one of two registers on the register bus: 0 is the flag register and 1 is the enable register. Read data is combinational.

Top module: `tmr_irq_flags`

## Requirements
- R1: The source order on `ack` and `irq` is overflow=0, compare A=1, compare B=2, compare C=3, capture=4. In both registers, overflow is bit 0, compare A is bit 1, compare B is bit 2, compare C is bit 3 and capture is bit 5. After reset, every flag, every enable bit and every request is zero.
- R2: Bits 7, 6 and 4 of both registers always read as zero, and writing to them has no effect.
- R3: `irq[i]` is one exactly when flag i is set, enable bit i is set and `gie` is one.
- R4: A flag-register write clears each flag whose bit in `bus_wdata` is one. Flags whose bit is zero keep their value.
- R5: A one on `ack[i]` for one cycle clears flag i and leaves every other flag unchanged.
- R6: A set strobe and a clear (write-one or acknowledge) may hit the same flag in the same cycle. The flag then ends up set.
- R7: A compare match counts only in a cycle where `tick` is one. Its flag is set at the end of the next cycle in which `tick` is one, and is not yet set right after the match cycle.
- R8: A `force_cmp` strobe never sets a compare flag.
- R9: With `cap_is_top` zero, `cap_evt` sets the capture flag and `at_top` is ignored. With `cap_is_top` one, `at_top` sets the capture flag and `cap_evt` is ignored.
- R10: `ovf_evt` sets the overflow flag at the next clock edge.
- R11: The enable register reads back the last value written to it, masked to the implemented bits (value AND 0x2F), on `bus_rdata` in the same cycle that `bus_addr` selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable (prescaler output) |
| cap_evt | input | 1 | Capture-pin event strobe |
| at_top | input | 1 | Counter-at-TOP strobe |
| cap_is_top | input | 1 | Mode: capture register used as TOP |
| cmp_match | input | 3 | Compare match strobes, bit 0 = A, 1 = B, 2 = C |
| force_cmp | input | 3 | Forced compare strobes, same order |
| ovf_evt | input | 1 | Counter overflow strobe |
| gie | input | 1 | Global interrupt enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 flags, 1 enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of selected register |
| ack | input | 5 | Per-source vector acknowledge pulses |
| irq | output | 5 | Per-source interrupt requests |

## Verification
The request gating is swept over all 32 flag patterns, all 32 enable patterns and both states of `gie`. This separates a missing AND term from a swapped bit position. Every 8-bit value is written to the enable register and read back, which exposes reserved-bit leakage. Single-bit write-one clears and single-source acknowledges are applied to a register with all flags set, so a clear that reaches the wrong neighbour shows up. The compare delay is tried with `tick` held high and with a sparse `tick`, which tells a delay of one clock from a delay of one timer clock. Set/clear collisions, forced strobes and both capture modes are each driven on their own.

// File: rtl/tif_pkg.sv
package tif_pkg;
    localparam int REG_W = 8;
    localparam int NSRC  = 5;
    localparam int NCMP  = 3;

    localparam int SRC_OVF = 0;
    localparam int SRC_CMP = 1;
    localparam int SRC_CAP = 4;

    localparam int BIT_CAP = 5;

    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    typedef enum logic {
        CD_IDLE  = 1'b0,
        CD_ARMED = 1'b1
    } cd_state_e;

    function automatic logic [REG_W-1:0] src_to_reg(input logic [NSRC-1:0] s);
        logic [REG_W-1:0] r;
        r = '0;
        r[NSRC-2:0] = s[NSRC-2:0];
        r[BIT_CAP]  = s[SRC_CAP];
        return r;
    endfunction

    function automatic logic [NSRC-1:0] reg_to_src(input logic [REG_W-1:0] r);
        logic [NSRC-1:0] s;
        s[NSRC-2:0] = r[NSRC-2:0];
        s[SRC_CAP]  = r[BIT_CAP];
        return s;
    endfunction
endpackage

// File: rtl/tif_cmp_delay.sv
module tif_cmp_delay
    import tif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    output logic set_o
);
    cd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_IDLE:  if (tick && match) state_d = CD_ARMED;
            CD_ARMED: if (tick)          state_d = match ? CD_ARMED : CD_IDLE;
            default:                     state_d = CD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        set_o = (state_q == CD_ARMED) && tick;
    end
endmodule

// File: rtl/tif_flag_bit.sv
module tif_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/tif_mask_reg.sv
module tif_mask_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cap_evt,
    input  logic             at_top,
    input  logic             cap_is_top,
    input  logic [NCMP-1:0]  cmp_match,
    input  logic [NCMP-1:0]  force_cmp,
    input  logic             ovf_evt,
    input  logic             gie,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]  ack,
    output logic [NSRC-1:0]  irq
);
    logic [NCMP-1:0] cmp_set;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] mask_q;
    logic            wr_flag;
    logic            wr_mask;
    logic            cap_set;

    assign wr_flag = bus_wr && (bus_addr == SEL_FLAG);
    assign wr_mask = bus_wr && (bus_addr == SEL_MASK);

    genvar c;
    generate
        for (c = 0; c < NCMP; c++) begin : g_cmp
            tif_cmp_delay u_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .match (cmp_match[c]),
                .set_o (cmp_set[c])
            );
        end
    endgenerate

    always_comb begin
        cap_set = cap_is_top ? at_top : cap_evt;
        set_vec = '0;
        set_vec[SRC_OVF]              = ovf_evt;
        set_vec[SRC_CMP +: NCMP]      = cmp_set;
        set_vec[SRC_CAP]              = cap_set;
        clr_vec = ack | ({NSRC{wr_flag}} & reg_to_src(bus_wdata));
    end

    genvar s;
    generate
        for (s = 0; s < NSRC; s++) begin : g_flag
            tif_flag_bit u_bit (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_vec[s]),
                .clr_i  (clr_vec[s]),
                .flag_o (flag_q[s])
            );
        end
    endgenerate

    tif_mask_reg #(.W(NSRC)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_mask),
        .wdata (reg_to_src(bus_wdata)),
        .q     (mask_q)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_FLAG: bus_rdata = src_to_reg(flag_q);
            SEL_MASK: bus_rdata = src_to_reg(mask_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = flag_q & mask_q & {NSRC{gie}};
endmodule

// File: rtl/tif_chk.sv
module tif_chk
    import tif_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             gie,
    input logic             cap_is_top,
    input logic             at_top,
    input logic             ovf_evt,
    input logic [NCMP-1:0]  cmp_match,
    input logic [NCMP-1:0]  force_cmp,
    input logic [NSRC-1:0]  ack,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] bus_rdata,
    input logic [NSRC-1:0]  irq,
    input logic [NSRC-1:0]  flag_q,
    input logic [NSRC-1:0]  mask_q,
    input logic [NSRC-1:0]  set_vec,
    input logic [NCMP-1:0]  cmp_set
);
    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[7:6] == 2'b00) && !bus_rdata[4]);

    p_irq_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> gie);

    p_irq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~(flag_q & mask_q)) == '0));

    p_wr0_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_FLAG && !bus_wdata[0] && !ack[SRC_OVF] && flag_q[SRC_OVF])
        |=> flag_q[SRC_OVF]);

    p_cap_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_is_top && !at_top && !flag_q[SRC_CAP]) |=> !flag_q[SRC_CAP]);

    p_ovf_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flag_q[SRC_OVF]);

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_src
            p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (ack[i] && !set_vec[i]) |=> !flag_q[i]);
            p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> flag_q[i]);
        end
        for (i = 0; i < NCMP; i++) begin : g_cmp
            p_force_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && force_cmp[i] && !cmp_match[i] && !cmp_set[i] && !flag_q[SRC_CMP+i])
                |=> !flag_q[SRC_CMP+i]);
            p_cmp_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q[SRC_CMP+i]) |-> $past(tick));
        end
    endgenerate
endmodule

bind tmr_irq_flags tif_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .gie        (gie),
    .cap_is_top (cap_is_top),
    .at_top     (at_top),
    .ovf_evt    (ovf_evt),
    .cmp_match  (cmp_match),
    .force_cmp  (force_cmp),
    .ack        (ack),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .flag_q     (flag_q),
    .mask_q     (mask_q),
    .set_vec    (set_vec),
    .cmp_set    (cmp_set)
);

// File: tb/sim_tmr_irq_flags.sv
module sim_tmr_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cap_evt = 1'b0;
    logic       at_top = 1'b0;
    logic       cap_is_top = 1'b0;
    logic [2:0] cmp_match = '0;
    logic [2:0] force_cmp = '0;
    logic       ovf_evt = 1'b0;
    logic       gie = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] ack = '0;
    logic [4:0] irq;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr_irq_flags u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap_evt(cap_evt), .at_top(at_top),
        .cap_is_top(cap_is_top), .cmp_match(cmp_match), .force_cmp(force_cmp),
        .ovf_evt(ovf_evt), .gie(gie), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack(ack), .irq(irq)
    );

    function automatic logic [7:0] map(input logic [4:0] s);
        return {2'b00, s[4], 1'b0, s[3:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        bus_addr = sel; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        bus_addr = sel;
        #1 v = bus_rdata;
    endtask

    task automatic set_flags(input logic [4:0] f);
        wr(1'b0, 8'hFF);
        ovf_evt = f[0]; cmp_match = f[3:1]; cap_evt = f[4]; tick = 1'b1;
        cyc();
        ovf_evt = 1'b0; cmp_match = '0; cap_evt = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        repeat (3) cyc();
        // R1: reset state
        rd(1'b0, v); chk("R1 flags after reset", v, 8'h00);
        rd(1'b1, v); chk("R1 enables after reset", v, 8'h00);
        chk("R1 irq after reset", irq, 5'h00);
        rst_n = 1'b1; tick = 1'b1;
        cyc();

        // R11, R2: enable register readback over all byte values
        for (int w = 0; w < 256; w++) begin
            wr(1'b1, w[7:0]);
            rd(1'b1, v);
            chk("R11 R2 enable readback", v, w[7:0] & 8'h2F);
        end

        // R2: reserved flag bits
        set_flags(5'h1F);
        rd(1'b0, v); chk("R2 flag reserved bits", v, 8'h2F);
        wr(1'b0, 8'hD0);
        rd(1'b0, v); chk("R2 reserved write no effect", v, 8'h2F);

        // R3, R1, R9, R10: full sweep of flags, enables and gie
        for (int f = 0; f < 32; f++) begin
            set_flags(f[4:0]);
            rd(1'b0, v); chk("R1 flag pattern", v, map(f[4:0]));
            for (int m = 0; m < 32; m++) begin
                wr(1'b1, map(m[4:0]));
                for (int g = 0; g < 2; g++) begin
                    gie = g[0];
                    #1 chk("R3 irq gating", irq, f[4:0] & m[4:0] & {5{g[0]}});
                end
            end
        end
        gie = 1'b0;

        // R4: write-one clears a single flag
        for (int i = 0; i < 5; i++) begin
            set_flags(5'h1F);
            wr(1'b0, map(5'(1 << i)));
            rd(1'b0, v); chk("R4 write-one clear", v, map(5'h1F & ~5'(1 << i)));
        end
        set_flags(5'h1F);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk("R4 write-zero keeps", v, 8'h2F);

        // R5: acknowledge clears only its source
        for (int i = 0; i < 5; i++) begin
            set_flags(5'h1F);
            ack = 5'(1 << i);
            cyc();
            ack = '0;
            rd(1'b0, v); chk("R5 ack clear", v, map(5'h1F & ~5'(1 << i)));
        end

        // R6: set beats clear in the same cycle
        set_flags(5'h00);
        ovf_evt = 1'b1; cap_evt = 1'b1; ack = 5'h11;
        cyc();
        ovf_evt = 1'b0; cap_evt = 1'b0; ack = '0;
        rd(1'b0, v); chk("R6 set wins over ack", v, 8'h21);
        ovf_evt = 1'b1;
        wr(1'b0, 8'h01);
        ovf_evt = 1'b0;
        rd(1'b0, v); chk("R6 set wins over write-one", v, 8'h21);

        // R7: compare delay with continuous tick
        set_flags(5'h00);
        cmp_match = 3'b100;
        cyc();
        cmp_match = '0;
        rd(1'b0, v); chk("R7 not set in match cycle", v, 8'h00);
        cyc();
        rd(1'b0, v); chk("R7 set one timer clock later", v, 8'h08);

        // R7: compare delay under a sparse tick
        set_flags(5'h00);
        tick = 1'b0; cmp_match = 3'b001;
        cyc();
        cmp_match = '0;
        repeat (3) cyc();
        rd(1'b0, v); chk("R7 match without tick ignored", v, 8'h00);
        tick = 1'b1; cmp_match = 3'b001;
        cyc();
        tick = 1'b0; cmp_match = '0;
        rd(1'b0, v); chk("R7 not set at match tick", v, 8'h00);
        repeat (3) cyc();
        rd(1'b0, v); chk("R7 waits for next tick", v, 8'h00);
        tick = 1'b1;
        cyc();
        tick = 1'b0;
        rd(1'b0, v); chk("R7 set on next tick", v, 8'h02);
        tick = 1'b1;

        // R8: forced compare never sets a flag
        set_flags(5'h00);
        force_cmp = 3'b111;
        repeat (4) cyc();
        force_cmp = '0;
        cyc();
        rd(1'b0, v); chk("R8 force no flag", v, 8'h00);

        // R9: capture source selection
        set_flags(5'h00);
        at_top = 1'b1; cyc(); at_top = 1'b0;
        rd(1'b0, v); chk("R9 top ignored in pin mode", v, 8'h00);
        cap_evt = 1'b1; cyc(); cap_evt = 1'b0;
        rd(1'b0, v); chk("R9 pin event sets", v, 8'h20);
        set_flags(5'h00);
        cap_is_top = 1'b1;
        cap_evt = 1'b1; cyc(); cap_evt = 1'b0;
        rd(1'b0, v); chk("R9 pin ignored in top mode", v, 8'h00);
        at_top = 1'b1; cyc(); at_top = 1'b0;
        rd(1'b0, v); chk("R9 top sets in top mode", v, 8'h20);
        cap_is_top = 1'b0;

        // R10: overflow
        set_flags(5'h00);
        ovf_evt = 1'b1; cyc(); ovf_evt = 1'b0;
        rd(1'b0, v); chk("R10 overflow sets", v, 8'h01);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule